// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is a 32-bit countdown timer for a processor's local interrupt logic. Software sets three things. The first is a start value. The second is a prescale code that divides the input clock by a power of two. The third is a control entry that holds an interrupt vector, a suppress bit and a repeat bit. Loading the start value begins a countdown straight away. The live count can be read on a port at any time.

When the count steps from one to zero, the block raises a single-cycle request strobe that carries the vector, unless the suppress bit is set. In one-shot operation the count then stays at zero. In repeat operation the next prescaled tick reloads the start value, so the interval between requests is the start value plus one ticks. A start value of zero leaves the timer idle.

Top module: `lcl_timer`

## Requirements
- R1: A prescale write keeps only bits 0, 1 and 3 of the data. `cfgDiv` shows those bits in their own positions and bit 2 always reads 0.
- R2: The prescale code is {bit3, bit1, bit0}, with bit 3 as the most significant bit. The count steps once every 2^((code+1) mod 8) clocks, so code 7 divides by 1 and code 6 divides by 128. In one-shot operation the request appears start<<shift clock edges after the start-value write.
- R3: A start-value write shows the new value on `curCount` in the next cycle and restarts the prescaler from zero. It has this effect even while a countdown is in progress.
- R4: `curCount` falls by exactly one on each prescaled tick. In one-shot operation (control bit 17 = 0) it stays at zero once it gets there.
- R5: In repeat operation (control bit 17 = 1), the tick after the count reaches zero reloads the start value. Requests are therefore start+1 ticks apart.
- R6: The request `fireValid` is high for exactly one cycle. That cycle is the first one in which `curCount` reads zero, and `fireVector` carries control bits 7:0.
- R7: When control bit 16 (suppress) is set, no request is raised, but counting goes on unchanged.
- R8: A control write takes effect at once. If the count is already held at zero in one-shot operation, setting bit 17 makes the next tick reload the count.
- R9: A start value of zero keeps the count at zero and raises no request, in either operation.
- R10: After reset the count is 0, no request is active, the control entry has suppress set, one-shot operation and vector 0, and the prescale code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrInit | input | 1 | Write strobe for the start value |
| wrDiv | input | 1 | Write strobe for the prescale code |
| wrEntry | input | 1 | Write strobe for the control entry |
| wrData | input | 32 | Data shared by all three write strobes |
| curCount | output | 32 | Live count value |
| cfgDiv | output | 4 | Read-back of the stored prescale bits |
| fireValid | output | 1 | Single-cycle request strobe |
| fireVector | output | 8 | Vector that goes with the request |

## Verification
The bench checks expiry latency against start<<shift for codes whose top bit is set and for codes whose top bit is clear. A design that dropped bit 3 or skipped the mod-8 wrap would be off by factors of 16 or more. The bench measures the repeat interval to catch a reload on the same tick as zero, which would shorten the period to start ticks. It restarts the count in mid-flight to show that the prescaler phase is cleared. It also checks that a suppressed entry, or a start value of zero, never raises a strobe. Finally, it sets repeat operation while the count is held at zero, which exposes a design that only re-arms on a start-value write.

// File: rtl/lcl_timer_pkg.sv
package lcl_timer_pkg;
  // width of the prescale code and the resulting shift
  localparam int SHIFT_W = 3;
  // prescaler counter must reach 2^(2^SHIFT_W - 1) - 1
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  typedef struct packed {
    logic load;    // take the start value
    logic dec;     // step down by one
    logic reload;  // repeat operation: copy the start value back
  } cnt_ops_t;
endpackage

// File: rtl/lcl_timer_pre.sv
module lcl_timer_pre
  import lcl_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] divCode,
  output logic               tick
);
  logic [SHIFT_W-1:0] shiftAmt;
  logic [PRE_W-1:0]   termVal;
  logic [PRE_W-1:0]   preCnt;

  always_comb begin
    shiftAmt = divCode + SHIFT_W'(1);
    termVal  = (PRE_W'(1) << shiftAmt) - PRE_W'(1);
    tick     = !restart && (preCnt >= termVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (restart || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/lcl_timer_ctl.sv
module lcl_timer_ctl
  import lcl_timer_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrInit,
  input  logic             wrDiv,
  input  logic             wrEntry,
  input  logic [3:0]       divIn,
  input  logic [VEC_W-1:0] vecIn,
  input  logic             maskIn,
  input  logic             modeIn,
  input  logic             isZero,
  input  logic             isOne,
  input  logic             initNonZero,
  output cnt_ops_t         ops,
  output logic [3:0]       cfgDiv,
  output logic             fireValid,
  output logic [VEC_W-1:0] fireVector
);
  logic [SHIFT_W-1:0] divCode;
  logic [VEC_W-1:0]   vecReg;
  logic               maskReg;
  logic               perReg;
  logic               tick;
  logic               expire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCode <= '0;
      vecReg  <= '0;
      maskReg <= 1'b1;
      perReg  <= 1'b0;
    end else begin
      if (wrDiv) divCode <= {divIn[3], divIn[1:0]};
      if (wrEntry) begin
        vecReg  <= vecIn;
        maskReg <= maskIn;
        perReg  <= modeIn;
      end
    end
  end

  lcl_timer_pre uPre (
    .clk     (clk),
    .rstN    (rstN),
    .restart (wrInit),
    .divCode (divCode),
    .tick    (tick)
  );

  always_comb begin
    ops.load   = wrInit;
    ops.dec    = tick && !isZero;
    ops.reload = tick && isZero && perReg && initNonZero;
    expire     = tick && isOne;
    cfgDiv     = {divCode[2], 1'b0, divCode[1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fireValid  <= 1'b0;
      fireVector <= '0;
    end else begin
      fireValid <= expire && !maskReg;
      if (expire) fireVector <= vecReg;
    end
  end
endmodule

// File: rtl/lcl_timer_dp.sv
module lcl_timer_dp
  import lcl_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_ops_t         ops,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] curCount,
  output logic             isZero,
  output logic             isOne,
  output logic             initNonZero
);
  logic [CNT_W-1:0] initReg;
  logic [CNT_W-1:0] countReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initReg  <= '0;
      countReg <= '0;
    end else if (ops.load) begin
      initReg  <= wrData;
      countReg <= wrData;
    end else if (ops.dec) begin
      countReg <= countReg - CNT_W'(1);
    end else if (ops.reload) begin
      countReg <= initReg;
    end
  end

  always_comb begin
    curCount    = countReg;
    isZero      = (countReg == '0);
    isOne       = (countReg == CNT_W'(1));
    initNonZero = (initReg != '0);
  end
endmodule

// File: rtl/lcl_timer.sv
module lcl_timer
  import lcl_timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int VEC_W    = 8,
  parameter int MASK_BIT = 16,
  parameter int MODE_BIT = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrInit,
  input  logic             wrDiv,
  input  logic             wrEntry,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] curCount,
  output logic [3:0]       cfgDiv,
  output logic             fireValid,
  output logic [VEC_W-1:0] fireVector
);
  cnt_ops_t ops;
  logic     isZero;
  logic     isOne;
  logic     initNonZero;

  lcl_timer_ctl #(.VEC_W(VEC_W)) uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .wrInit      (wrInit),
    .wrDiv       (wrDiv),
    .wrEntry     (wrEntry),
    .divIn       (wrData[3:0]),
    .vecIn       (wrData[VEC_W-1:0]),
    .maskIn      (wrData[MASK_BIT]),
    .modeIn      (wrData[MODE_BIT]),
    .isZero      (isZero),
    .isOne       (isOne),
    .initNonZero (initNonZero),
    .ops         (ops),
    .cfgDiv      (cfgDiv),
    .fireValid   (fireValid),
    .fireVector  (fireVector)
  );

  lcl_timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .ops         (ops),
    .wrData      (wrData),
    .curCount    (curCount),
    .isZero      (isZero),
    .isOne       (isOne),
    .initNonZero (initNonZero)
  );
endmodule

// File: rtl/lcl_timer_chk.sv
module lcl_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrInit,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] curCount,
  input logic             fireValid
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    wrInit |=> curCount == $past(wrData)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrInit && curCount != '0) |=>
      (curCount == $past(curCount) || curCount == $past(curCount) - CNT_W'(1))); // R4

  AST_FIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    fireValid |-> curCount == '0); // R6

  AST_FIRE_FROM_ONE: assert property (@(posedge clk) disable iff (!rstN)
    fireValid |-> $past(curCount) == CNT_W'(1)); // R6

  AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    fireValid |=> !fireValid); // R6

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrInit && wrData == '0) |=> (curCount == '0 && !fireValid)); // R9
endmodule

bind lcl_timer lcl_timer_chk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrInit    (wrInit),
  .wrData    (wrData),
  .curCount  (curCount),
  .fireValid (fireValid)
);

// File: tb/tb_lcl_timer.sv
`timescale 1ns/1ps
module tb_lcl_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrInit = 1'b0, wrDiv = 1'b0, wrEntry = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] curCount;
  logic [3:0]  cfgDiv;
  logic        fireValid;
  logic [7:0]  fireVector;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lcl_timer dut (
    .clk(clk), .rstN(rstN), .wrInit(wrInit), .wrDiv(wrDiv), .wrEntry(wrEntry),
    .wrData(wrData), .curCount(curCount), .cfgDiv(cfgDiv),
    .fireValid(fireValid), .fireVector(fireVector)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mCount, mInit;
  int  mCode, mPre, mVec, mShift, mTerm;
  bit  mMask, mPer, mFire, mTick, mExp;
  int  mFVec;

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mInit = 0; mCode = 0; mPre = 0; mVec = 0;
      mMask = 1; mPer = 0; mFire = 0; mFVec = 0;
    end else begin
      mShift = (mCode + 1) % 8;
      mTerm  = (1 << mShift) - 1;
      mTick  = !wrInit && (mPre >= mTerm);
      mExp   = mTick && (mCount == 1);
      mFire  = mExp && !mMask;
      if (mExp) mFVec = mVec;
      if (wrInit || mTick) mPre = 0; else mPre = mPre + 1;
      if (wrInit) begin
        mCount = wrData; mInit = wrData;
      end else if (mTick && mCount != 0) begin
        mCount = mCount - 1;
      end else if (mTick && mPer && mInit != 0) begin
        mCount = mInit;
      end
      if (wrDiv) mCode = int'(wrData[3]) * 4 + int'(wrData[1:0]);
      if (wrEntry) begin
        mVec = int'(wrData[7:0]); mMask = wrData[16]; mPer = wrData[17];
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(curCount == mCount, "R4", "model curCount", curCount, mCount);
      chk(fireValid == mFire, "R6", "model fireValid", fireValid, mFire);
      chk(fireVector == mFVec[7:0], "R6", "model fireVector", fireVector, mFVec);
      chk(cfgDiv == {mCode[2], 1'b0, mCode[1:0]}, "R1", "model cfgDiv", cfgDiv, mCode);
    end
  end

  task automatic wr(input int kind, input logic [31:0] d);
    @(negedge clk);
    wrData = d; wrInit = (kind == 0); wrDiv = (kind == 1); wrEntry = (kind == 2);
    @(negedge clk);
    wrInit = 0; wrDiv = 0; wrEntry = 0;
  endtask

  task automatic waitFire(input int lim, output int n);
    n = 0;
    while (!fireValid && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  int n, n2, fires;
  bit sawZero;
  int divs[5] = '{32'hB, 32'h0, 32'h3, 32'h8, 32'hA};
  int shs[5]  = '{0, 1, 4, 5, 7};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(curCount == 0, "R10", "reset count", curCount, 0);
    chk(!fireValid, "R10", "reset strobe", fireValid, 0);
    chk(cfgDiv == 0, "R10", "reset divide", cfgDiv, 0);
    // default entry is suppressed: a short countdown raises nothing
    wr(0, 2);
    fires = 0;
    repeat (10) begin @(negedge clk); if (fireValid) fires++; end
    chk(fires == 0, "R10", "reset entry suppressed", fires, 0);

    wr(1, 32'hFFFF_FFFF);
    chk(cfgDiv == 4'hB, "R1", "divide bits kept", cfgDiv, 11);

    wr(2, 32'h0000_005A);
    for (int i = 0; i < 5; i++) begin
      wr(1, divs[i]);
      wr(0, 3);
      waitFire(2000, n);
      chk(n == (3 << shs[i]), "R2", "expiry latency", n, 3 << shs[i]);
      chk(fireVector == 8'h5A, "R6", "vector", fireVector, 8'h5A);
      @(negedge clk);
      chk(!fireValid, "R6", "single-cycle strobe", fireValid, 0);
      repeat (4) @(negedge clk);
      chk(curCount == 0, "R4", "one-shot holds zero", curCount, 0);
    end

    wr(1, 32'hB);
    wr(0, 100);
    repeat (7) @(negedge clk);
    chk(curCount == 93, "R4", "readable count", curCount, 93);

    wr(0, 10);
    repeat (3) @(negedge clk);
    wr(0, 6);
    chk(curCount == 6, "R3", "restart value", curCount, 6);
    waitFire(100, n);
    chk(n == 6, "R3", "restart latency", n, 6);

    wr(1, 32'h0);
    wr(0, 5);
    repeat (3) @(negedge clk);
    wr(0, 2);
    waitFire(100, n);
    chk(n == 4, "R3", "prescaler phase cleared", n, 4);

    wr(1, 32'hB);
    wr(2, 32'h0002_0033);
    wr(0, 3);
    waitFire(100, n);
    @(negedge clk);
    chk(curCount == 3, "R5", "reload value", curCount, 3);
    waitFire(100, n2);
    chk(n2 + 1 == 4, "R5", "repeat period", n2 + 1, 4);
    chk(fireVector == 8'h33, "R6", "repeat vector", fireVector, 8'h33);

    wr(2, 32'h0003_0044);
    wr(0, 2);
    fires = 0; sawZero = 0;
    repeat (20) begin
      @(negedge clk);
      if (fireValid) fires++;
      if (curCount == 0) sawZero = 1;
    end
    chk(fires == 0, "R7", "suppressed strobe", fires, 0);
    chk(sawZero, "R7", "counting continues", sawZero, 1);

    wr(2, 32'h0000_0011);
    wr(0, 2);
    waitFire(100, n);
    chk(n == 2, "R8", "one-shot first", n, 2);
    repeat (4) @(negedge clk);
    chk(curCount == 0, "R8", "held at zero", curCount, 0);
    wr(2, 32'h0002_0011);
    waitFire(100, n);
    chk(n == 3, "R8", "re-armed by entry write", n, 3);

    wr(2, 32'h0002_0022);
    wr(0, 0);
    fires = 0;
    repeat (30) begin
      @(negedge clk);
      if (fireValid) fires++;
    end
    chk(fires == 0, "R9", "zero start no strobe", fires, 0);
    chk(curCount == 0, "R9", "zero start stays", curCount, 0);

    // mixed traffic compared against the model each cycle
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      wrInit = 0; wrDiv = 0; wrEntry = 0;
      case ($urandom_range(0, 9))
        0: begin wrInit = 1; wrData = $urandom_range(0, 12); end
        1: begin wrDiv = 1; wrData = $urandom_range(0, 15) & 32'hB | 32'h3; end
        2: begin wrEntry = 1; wrData = {14'd0, 2'($urandom_range(0, 3)), 8'd0, 8'($urandom)}; end
        default: ;
      endcase
    end
    @(negedge clk);
    wrInit = 0; wrDiv = 0; wrEntry = 0;
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule